// File: doc/BRIEF.md
# Interval Decrementer Timer

This block is a down-counting interval timer. It runs off the same tick as a free-running time base elsewhere in the chip. Software writes a start value through a small write port, and the counter then loses one on every tick. When the counter reaches its end, the block sets a sticky status flag. It raises an interrupt if that interrupt has been enabled.

The tick has two possible sources, chosen by a control bit:
- the core clock, which gives one tick every cycle;
- an asynchronous external timer clock, which gives one tick per rising edge after synchronisation.

An auto-reload control bit sets what happens at expiry. With it set, the counter takes the last written value again and the timer runs periodically. With it clear, the counter stops at zero.

Top module: `idt_timer`

## Requirements
- R1: After reset the count, the control bits, the status flag and the interrupt are all 0.
- R2: A write to address 0 loads the count and its reload shadow with the written data. The new count is visible after that clock edge, and the load takes priority over any tick in the same cycle.
- R3: On each tick where the count is above 1 and no load happens, the count drops by exactly 1. Without a tick the count is unchanged. This holds across the full count width.
- R4: When control bit 2 (source select) is 0, there is one tick on every clock cycle.
- R5: When control bit 2 is 1, the external clock passes through a two-flop synchroniser and an edge detector. Each rising edge gives exactly one single-cycle tick, and that tick takes effect on the third clock edge after the rising edge is first sampled. A held level gives no further ticks.
- R6: A tick taken at a count of 1 is an expiry. It sets the status flag. With control bit 1 (auto-reload) at 0, the count becomes 0 and stays there until the next load.
- R7: With auto-reload at 1, an expiry loads the count from the shadow, which holds the most recently written start value, and counting continues.
- R8: A count of 0 is idle: ticks leave it at 0 and no expiry occurs.
- R9: The status flag (readable on `status_o`) is sticky. A write to address 2 with data bit 0 set clears it. A write to address 2 with data bit 0 clear leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R10: The interrupt output is a level equal to the status flag ANDed with control bit 0 (interrupt enable).
- R11: A write to address 1 stores data bits 2:0 into the control register, which is visible on `ctrl_o`. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_tick_clk_i | input | 1 | Asynchronous external timer clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 count, 1 control, 2 status clear, 3 unused |
| wr_data_i | input | WIDTH | Write data |
| count_o | output | WIDTH | Current count |
| ctrl_o | output | 3 | Control bits: 0 interrupt enable, 1 auto-reload, 2 external source |
| status_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block at its default parameters: a 32-bit count and a two-stage synchroniser. The full width lets the bench load the all-ones value and see the first decrement without truncation. Keeping the real synchroniser depth lets the bench confirm the three-edge latency from an external rising edge to its decrement. A behavioural reference model, driven by a history queue of sampled external clock values, is compared against every output on every clock. Directed sequences cover expiry with and without reload, a zero load, a clear that coincides with expiry, and writes that must have no effect.

// File: rtl/idt_pkg.sv
package idt_pkg;
  localparam int CTRL_W        = 3;
  localparam int ADDR_W        = 2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;
  localparam int STATUS_CLR_BIT = 0;

  typedef struct packed {
    logic ext_sel;
    logic reload;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/idt_tick_gen.sv
module idt_tick_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  input  logic ext_sel_i,
  output logic tick_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   ext_edge;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= ext_clk_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[LAST];
  end

  assign ext_edge = sync_q[LAST] & ~prev_q;
  assign tick_o   = ext_sel_i ? ext_edge : 1'b1;
endmodule

// File: rtl/idt_countdown.sv
module idt_countdown #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             reload_en_i,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] shadow_o,
  output logic             expire_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] shadow_q;

  function automatic logic at_end(input logic [WIDTH-1:0] cur);
    return cur == ONE;
  endfunction

  function automatic logic [WIDTH-1:0] step_down(
    input logic [WIDTH-1:0] cur,
    input logic [WIDTH-1:0] shadow,
    input logic             reload
  );
    if (at_end(cur)) return reload ? shadow : '0;
    if (cur == '0)   return '0;
    return cur - ONE;
  endfunction

  assign expire_o = tick_i & ~load_i & at_end(count_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      shadow_q <= '0;
    end else if (load_i) begin
      count_q  <= load_val_i;
      shadow_q <= load_val_i;
    end else if (tick_i) begin
      count_q  <= step_down(count_q, shadow_q, reload_en_i);
    end
  end

  assign count_o  = count_q;
  assign shadow_o = shadow_q;
endmodule

// File: rtl/idt_regs.sv
module idt_regs
  import idt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CTRL_W-1:0] wr_bits_i,
  input  logic              expire_i,
  output ctrl_t             ctrl_o,
  output logic              status_o,
  output logic              irq_o
);
  ctrl_t ctrl_q;
  logic  status_q;
  logic  ctrl_we;
  logic  status_clr;

  assign ctrl_we    = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign status_clr = wr_en_i && (wr_addr_i == ADDR_STATUS) && wr_bits_i[STATUS_CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_t'(wr_bits_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         status_q <= 1'b0;
    else if (expire_i)   status_q <= 1'b1;
    else if (status_clr) status_q <= 1'b0;
  end

  assign ctrl_o   = ctrl_q;
  assign status_o = status_q;
  assign irq_o    = status_q & ctrl_q.irq_en;
endmodule

// File: rtl/idt_timer.sv
module idt_timer
  import idt_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_tick_clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  output logic [WIDTH-1:0]  count_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              status_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic             tick;
  logic             expire;
  logic             load_count;
  logic [WIDTH-1:0] shadow;

  assign load_count = wr_en_i && (wr_addr_i == ADDR_COUNT);

  idt_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_clk_i (ext_tick_clk_i),
    .ext_sel_i (ctrl.ext_sel),
    .tick_o    (tick)
  );

  idt_countdown #(.WIDTH(WIDTH)) u_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_count),
    .load_val_i  (wr_data_i),
    .tick_i      (tick),
    .reload_en_i (ctrl.reload),
    .count_o     (count_o),
    .shadow_o    (shadow),
    .expire_o    (expire)
  );

  idt_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_bits_i (wr_data_i[CTRL_W-1:0]),
    .expire_i  (expire),
    .ctrl_o    (ctrl),
    .status_o  (status_o),
    .irq_o     (irq_o)
  );

  assign ctrl_o = ctrl;
endmodule

// File: rtl/idt_timer_checker.sv
module idt_timer_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic [WIDTH-1:0] count_o,
  input logic [2:0]       ctrl_o,
  input logic             status_o,
  input logic             irq_o,
  input logic             tick,
  input logic             expire,
  input logic             load_count,
  input logic [WIDTH-1:0] shadow
);
  logic clr_req;
  logic ctrl_wr;
  assign clr_req = wr_en_i && (wr_addr_i == 2'd2) && wr_data_i[0];
  assign ctrl_wr = wr_en_i && (wr_addr_i == 2'd1);

  AST_LOAD_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd0) |=> count_o == $past(wr_data_i)); // R2
  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_count && tick && count_o > WIDTH'(1)) |=> count_o == $past(count_o) - WIDTH'(1)); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_count && !tick) |=> $stable(count_o)); // R3
  AST_INTERNAL_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[2] |-> tick); // R4
  AST_EXT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[2] && tick && !ctrl_wr) |=> !tick); // R5
  AST_EXPIRE_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !ctrl_o[1]) |=> count_o == '0); // R6
  AST_EXPIRE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> status_o); // R6
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && ctrl_o[1]) |=> count_o == $past(shadow)); // R7
  AST_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |-> !expire); // R8
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !clr_req) |=> status_o); // R9
  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && ctrl_o[0] && !ctrl_wr) |=> irq_o); // R10
  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> ctrl_o == $past(wr_data_i[2:0])); // R11
endmodule

bind idt_timer idt_timer_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .count_o    (count_o),
  .ctrl_o     (ctrl_o),
  .status_o   (status_o),
  .irq_o      (irq_o),
  .tick       (tick),
  .expire     (expire),
  .load_count (load_count),
  .shadow     (shadow)
);

// File: tb/idt_timer_bench.sv
`timescale 1ns/1ps
module idt_timer_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ext_clk = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count;
  logic [2:0]   ctrl;
  logic         status;
  logic         irq;

  int  total = 0;
  int  fails = 0;
  int  cyc   = 0;
  bit  done  = 0;
  bit  live  = 0;

  always #4 clk = ~clk;

  idt_timer #(.WIDTH(W), .SYNC_STAGES(2)) u_idt_timer (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .ext_tick_clk_i (ext_clk),
    .wr_en_i        (wr_en),
    .wr_addr_i      (wr_addr),
    .wr_data_i      (wr_data),
    .count_o        (count),
    .ctrl_o         (ctrl),
    .status_o       (status),
    .irq_o          (irq)
  );

  // Behavioural reference model
  longint unsigned m_count, m_shadow;
  int  m_ctrl;
  bit  m_status;
  bit  ext_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_count = 0; m_shadow = 0; m_ctrl = 0; m_status = 0;
      ext_hist = '{0, 0, 0};
    end else begin
      bit t, exp_now;
      // ext_hist[0] sampled one edge ago, [1] two ago, [2] three ago
      t = ((m_ctrl >> 2) & 1) ? (ext_hist[1] && !ext_hist[2]) : 1'b1;
      exp_now = 0;
      if (wr_en && wr_addr == 0) begin
        m_count = wr_data; m_shadow = wr_data;
      end else if (t && m_count != 0) begin
        if (m_count == 1) begin
          exp_now = 1;
          m_count = ((m_ctrl >> 1) & 1) ? m_shadow : 0;
        end else m_count = m_count - 1;
      end
      if (exp_now) m_status = 1;
      else if (wr_en && wr_addr == 2 && wr_data[0]) m_status = 0;
      if (wr_en && wr_addr == 1) m_ctrl = int'(wr_data[2:0]);
      ext_hist.push_front(ext_clk);
      ext_hist = ext_hist[0:2];
    end
  end

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n) begin
      chk("R3 count vs model", count, m_count);
      chk("R9 status vs model", status, m_status);
      chk("R10 irq vs model", irq, m_status && (m_ctrl & 1));
      chk("R11 ctrl vs model", ctrl, m_ctrl);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<50000 cycles", cyc);
      finish_run();
    end
  end

  // Tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count at reset", count, 0);
    chk("R1 status at reset", status, 0);
    chk("R1 irq at reset", irq, 0);
    chk("R1 ctrl at reset", ctrl, 0);
    rst_n = 1;
    @(negedge clk);
    live = 1;

    // internal tick, one-shot
    wr(2'd1, 32'h1);
    chk("R11 ctrl write", ctrl, 1);
    wr(2'd0, 32'd5);
    chk("R2 load visible", count, 5);
    idle(1);
    chk("R4 tick every cycle", count, 4);
    idle(3);
    chk("R3 count at one", count, 1);
    idle(1);
    chk("R6 expiry to zero", count, 0);
    chk("R6 status set", status, 1);
    chk("R10 irq with enable", irq, 1);
    idle(3);
    chk("R6 holds at zero", count, 0);

    // W1C
    wr(2'd2, 32'h0);
    chk("R9 write zero no clear", status, 1);
    wr(2'd2, 32'h1);
    chk("R9 write one clears", status, 0);
    chk("R10 irq follows status", irq, 0);

    // enable off
    wr(2'd1, 32'h0);
    wr(2'd0, 32'd2);
    idle(2);
    chk("R6 status without enable", status, 1);
    chk("R10 irq gated off", irq, 0);
    wr(2'd1, 32'h1);
    chk("R10 irq on enable", irq, 1);
    wr(2'd2, 32'h1);

    // auto-reload
    wr(2'd1, 32'h3);
    wr(2'd0, 32'd3);
    idle(2);
    chk("R7 before expiry", count, 1);
    idle(1);
    chk("R7 reload value", count, 3);
    chk("R7 status set", status, 1);
    idle(1);
    chk("R7 keeps counting", count, 2);

    // expiry coincides with clear: set wins
    wr(2'd2, 32'h1);
    wr(2'd0, 32'd2);
    idle(1);
    wr(2'd2, 32'h1);
    chk("R9 set wins over clear", status, 1);
    wr(2'd2, 32'h1);

    // load overrides tick
    wr(2'd0, 32'd7);
    chk("R2 load over tick", count, 7);

    // zero load
    wr(2'd0, 32'd0);
    idle(10);
    chk("R8 zero stays idle", count, 0);
    chk("R8 no expiry", status, 0);

    // full width
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R2 full width load", count, 32'hFFFF_FFFF);
    idle(1);
    chk("R3 full width decrement", count, 32'hFFFF_FFFE);

    // address 3 ignored
    wr(2'd1, 32'h1);
    wr(2'd0, 32'd0);
    wr(2'd3, 32'hFFFF_FFFF);
    chk("R11 addr3 ctrl unchanged", ctrl, 1);
    chk("R11 addr3 count unchanged", count, 0);
    chk("R11 addr3 status unchanged", status, 0);

    // external source
    wr(2'd1, 32'h5);
    wr(2'd0, 32'd2);
    idle(10);
    chk("R5 no edge no tick", count, 2);
    ext_clk = 1;
    idle(2);
    chk("R5 synchroniser latency", count, 2);
    idle(1);
    chk("R5 tick after edge", count, 1);
    idle(10);
    chk("R5 held level one tick", count, 1);
    ext_clk = 0;
    idle(3);
    chk("R5 falling edge no tick", count, 1);
    ext_clk = 1;
    idle(3);
    chk("R5 second edge expires", count, 0);
    chk("R6 ext expiry status", status, 1);
    chk("R10 ext expiry irq", irq, 1);
    idle(2);
    finish_run();
  end
endmodule